// File: doc/BRIEF.md
# Single-Data-Rate Bus Target Transaction Engine

This block is the target side of the single-data-rate mode of a two-wire serial bus with a push-pull data phase. It watches oversampled clock and data lines, which are already synchronised to the system clock. It finds start, repeated-start and stop conditions, and it answers the broadcast header (address 0x7E with a write direction) by pulling the data line low in the ninth clock. After any start it also answers a header that carries its own dynamic address. The ninth bit of each data byte is not an acknowledge. On writes the controller sends an odd-parity bit, which the target checks. On reads the target sends a continuation flag that tells the controller whether another byte follows.

Write bytes go to a register file as single-cycle strobes, and each strobe is marked when it carries the first byte of a message (normally a register index). Read bytes come from the register file: the target captures the presented byte and its continuation flag when it starts to send them, then pulses a take strobe so that the source can advance. A byte sent directly after the broadcast header is a common command. Codes 0x00 to 0x7F are reported at once as broadcast commands. Codes 0x80 to 0xFF are held and reported as directed commands only when a later repeated-start header names this target. The reset-address command, as broadcast 0x06 or as 0x86 directed at this target, discards the dynamic address. A separate load strobe installs a new address.

Top module: `sdrt_target`

## Requirements
- R1: A start is SDA falling while SCL stays high, and a stop is SDA rising while SCL stays high. A header byte 0xFC (address 0x7E, direction bit 0) is acknowledged by driving SDA low through the ninth SCL clock, whether or not a dynamic address is held.
- R2: A header whose upper seven bits equal the held dynamic address is acknowledged, with bit 0 selecting write (0) or read (1). Any other header is not acknowledged, and SDA is not driven again until the next start or stop.
- R3: Write data arrives MSB first, followed by a ninth bit chosen so that the nine bits hold an odd number of ones. Each good byte gives one `wr_valid` pulse carrying the byte, and `wr_first` is 1 only for the first byte after the header.
- R4: A byte whose nine bits hold an even number of ones gives one `parity_err` pulse and is not delivered. Every later byte is ignored until the next start or stop.
- R5: On a read, the target sends `rd_data` MSB first, then sends as the ninth bit the `rd_more` value captured with that byte. It pulses `rd_take` once for each byte captured and releases SDA after a ninth bit of 0.
- R6: The first byte after an acknowledged broadcast header is a command. A code from 0x00 to 0x7F with good parity gives one `ccc_valid` pulse with `ccc_direct`=0. Bytes that follow it in that message are not delivered as writes.
- R7: A code from 0x80 to 0xFF is held. A later repeated-start header that matches this target is acknowledged and gives `ccc_valid` with `ccc_direct`=1 and the held code when the acknowledge bit ends. A stop drops the held code.
- R8: Command 0x06 (broadcast), or 0x86 when it is directed at this target, discards the dynamic address. After that, only the broadcast header is acknowledged.
- R9: Out of reset no dynamic address is held, and no directed header is acknowledged.
- R10: When `addr_set` reaches the address store in the same cycle as a discard, the load wins: the new address is held and is matched.
- R11: Out of reset, `sda_oe` and every strobe are 0. A stop releases SDA in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised SCL sample |
| sda_i | input | 1 | Synchronised SDA sample |
| sda_oe | output | 1 | Target drives SDA when 1 |
| sda_out | output | 1 | Value driven on SDA |
| addr_set | input | 1 | Load strobe for a new dynamic address |
| addr_new | input | 7 | Dynamic address to load |
| wr_valid | output | 1 | Write byte strobe |
| wr_first | output | 1 | Strobed byte is the first of its message |
| wr_data | output | 8 | Write byte |
| parity_err | output | 1 | Write parity failure strobe |
| rd_data | input | 8 | Byte offered for the next read |
| rd_more | input | 1 | Another byte follows the offered one |
| rd_take | output | 1 | Offered byte was captured; advance |
| ccc_valid | output | 1 | Common command strobe |
| ccc_direct | output | 1 | Command was directed at this target |
| ccc_code | output | 8 | Command code |

## Verification
Two actions can reach the address store in the same cycle: a discard raised by a decoded reset-address command, and a load from `addr_set`. The bench finds the cycle in which the discard strobe reaches the store: one clock after the engine sees the rising SCL edge of the command's parity bit. It pulses the load in that same cycle. The outcome is judged at the pins by a later header exchange: the newly loaded address must be acknowledged and the old one must not. The bench also checks that the command is still reported as a broadcast command in that message.

// File: rtl/sdrt_pkg.sv
package sdrt_pkg;
    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 7;
    localparam int FRAME_W   = BYTE_W + 1;
    localparam int CNT_W     = $clog2(FRAME_W + 1);

    localparam logic [ADDR_W-1:0] BCAST_ADDR     = 7'h7E;
    localparam logic [BYTE_W-1:0] CMD_DROP_ALL   = 8'h06;
    localparam logic [BYTE_W-1:0] CMD_DROP_ONE   = 8'h86;

    typedef enum logic [2:0] {
        ST_IDLE, ST_HDR, ST_ACK, ST_WR, ST_RD, ST_SKIP
    } phase_e;

    typedef enum logic [1:0] {
        CTX_CMD, CTX_CMD_DATA, CTX_PRIV, CTX_DCMD
    } ctx_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } line_ev_t;

    function automatic logic frame_odd(input logic [FRAME_W-1:0] f);
        return ^f;
    endfunction

    function automatic logic is_bcast_write(input logic [BYTE_W-1:0] h);
        return h == {BCAST_ADDR, 1'b0};
    endfunction
endpackage

// File: rtl/sdrt_line_events.sv
module sdrt_line_events
    import sdrt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev.rise  = scl_i & ~scl_q;
        ev.fall  = ~scl_i & scl_q;
        ev.start = scl_i & scl_q & sda_q & ~sda_i;
        ev.stop  = scl_i & scl_q & ~sda_q & sda_i;
    end
endmodule

// File: rtl/sdrt_addr_slot.sv
module sdrt_addr_slot #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_en,
    input  logic [AW-1:0] set_value,
    input  logic          clear,
    output logic          valid,
    output logic [AW-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            value <= '0;
        end else if (set_en) begin
            valid <= 1'b1;
            value <= set_value;
        end else if (clear) begin
            valid <= 1'b0;
        end
    end

    // R8: a discard with no load leaves no address
    assert_discard_empties_R8: assert property (@(posedge clk) disable iff (rst)
        (clear && !set_en) |=> !valid);
    // R10: a load beats a discard in the same cycle
    assert_load_beats_discard_R10: assert property (@(posedge clk) disable iff (rst)
        (set_en && clear) |=> (valid && value == $past(set_value)));
endmodule

// File: rtl/sdrt_frame_fsm.sv
module sdrt_frame_fsm
    import sdrt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sda_i,
    input  line_ev_t          ev,
    input  logic              da_valid,
    input  logic [ADDR_W-1:0] da_value,
    output logic              addr_clear,
    output logic              sda_oe,
    output logic              sda_out,
    output logic              wr_valid,
    output logic              wr_first,
    output logic [BYTE_W-1:0] wr_data,
    output logic              parity_err,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic              rd_more,
    output logic              rd_take,
    output logic              ccc_valid,
    output logic              ccc_direct,
    output logic [BYTE_W-1:0] ccc_code
);
    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] TBIT_POS  = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] TBIT_DONE = CNT_W'(BYTE_W + 1);

    phase_e            st;
    ctx_e              ctx;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg, pend_code;
    logic              pend_q, ack_ph, dir_rd, first_q, more_q;

    logic [BYTE_W-1:0] hdr_byte;
    logic              hdr_bcast, hdr_mine, frame_ok;

    always_comb begin
        hdr_byte  = {shreg[BYTE_W-2:0], sda_i};
        hdr_bcast = is_bcast_write(hdr_byte);
        hdr_mine  = da_valid && (hdr_byte[BYTE_W-1:1] == da_value);
        frame_ok  = frame_odd({shreg, sda_i});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            ctx        <= CTX_PRIV;
            cnt        <= '0;
            shreg      <= '0;
            pend_code  <= '0;
            pend_q     <= 1'b0;
            ack_ph     <= 1'b0;
            dir_rd     <= 1'b0;
            first_q    <= 1'b0;
            more_q     <= 1'b0;
            sda_oe     <= 1'b0;
            sda_out    <= 1'b1;
            wr_valid   <= 1'b0;
            wr_first   <= 1'b0;
            wr_data    <= '0;
            parity_err <= 1'b0;
            rd_take    <= 1'b0;
            ccc_valid  <= 1'b0;
            ccc_direct <= 1'b0;
            ccc_code   <= '0;
            addr_clear <= 1'b0;
        end else begin
            wr_valid   <= 1'b0;
            parity_err <= 1'b0;
            rd_take    <= 1'b0;
            ccc_valid  <= 1'b0;
            addr_clear <= 1'b0;
            if (ev.stop) begin
                st      <= ST_IDLE;
                sda_oe  <= 1'b0;
                sda_out <= 1'b1;
                pend_q  <= 1'b0;
            end else if (ev.start) begin
                st      <= ST_HDR;
                cnt     <= '0;
                sda_oe  <= 1'b0;
                sda_out <= 1'b1;
            end else begin
                unique case (st)
                    ST_HDR: if (ev.rise) begin
                        shreg <= hdr_byte;
                        cnt   <= cnt + 1'b1;
                        if (cnt == HDR_LAST) begin
                            ack_ph <= 1'b0;
                            if (hdr_bcast) begin
                                st     <= ST_ACK;
                                ctx    <= CTX_CMD;
                                dir_rd <= 1'b0;
                                pend_q <= 1'b0;
                            end else if (hdr_mine) begin
                                st     <= ST_ACK;
                                ctx    <= pend_q ? CTX_DCMD : CTX_PRIV;
                                dir_rd <= hdr_byte[0];
                            end else begin
                                st <= ST_SKIP;
                            end
                        end
                    end
                    ST_ACK: if (ev.fall) begin
                        if (!ack_ph) begin
                            sda_oe  <= 1'b1;
                            sda_out <= 1'b0;
                            ack_ph  <= 1'b1;
                        end else if (ctx == CTX_DCMD) begin
                            sda_oe     <= 1'b0;
                            sda_out    <= 1'b1;
                            ccc_valid  <= 1'b1;
                            ccc_direct <= 1'b1;
                            ccc_code   <= pend_code;
                            addr_clear <= (pend_code == CMD_DROP_ONE);
                            st         <= ST_SKIP;
                        end else if (dir_rd) begin
                            shreg   <= {rd_data[BYTE_W-2:0], 1'b0};
                            more_q  <= rd_more;
                            sda_out <= rd_data[BYTE_W-1];
                            sda_oe  <= 1'b1;
                            rd_take <= 1'b1;
                            cnt     <= CNT_W'(1);
                            st      <= ST_RD;
                        end else begin
                            sda_oe  <= 1'b0;
                            sda_out <= 1'b1;
                            cnt     <= '0;
                            first_q <= 1'b1;
                            st      <= ST_WR;
                        end
                    end
                    ST_WR: if (ev.rise) begin
                        if (cnt == TBIT_POS) begin
                            cnt <= '0;
                            if (!frame_ok) begin
                                parity_err <= 1'b1;
                                st         <= ST_SKIP;
                            end else begin
                                unique case (ctx)
                                    CTX_CMD: begin
                                        ctx <= CTX_CMD_DATA;
                                        if (shreg[BYTE_W-1]) begin
                                            pend_q    <= 1'b1;
                                            pend_code <= shreg;
                                        end else begin
                                            ccc_valid  <= 1'b1;
                                            ccc_direct <= 1'b0;
                                            ccc_code   <= shreg;
                                            addr_clear <= (shreg == CMD_DROP_ALL);
                                        end
                                    end
                                    CTX_PRIV: begin
                                        wr_valid <= 1'b1;
                                        wr_data  <= shreg;
                                        wr_first <= first_q;
                                        first_q  <= 1'b0;
                                    end
                                    default: ;
                                endcase
                            end
                        end else begin
                            shreg <= hdr_byte;
                            cnt   <= cnt + 1'b1;
                        end
                    end
                    ST_RD: if (ev.fall) begin
                        if (cnt < TBIT_POS) begin
                            sda_out <= shreg[BYTE_W-1];
                            shreg   <= shreg << 1;
                            cnt     <= cnt + 1'b1;
                        end else if (cnt == TBIT_POS) begin
                            sda_out <= more_q;
                            cnt     <= TBIT_DONE;
                        end else if (more_q) begin
                            shreg   <= {rd_data[BYTE_W-2:0], 1'b0};
                            more_q  <= rd_more;
                            sda_out <= rd_data[BYTE_W-1];
                            rd_take <= 1'b1;
                            cnt     <= CNT_W'(1);
                        end else begin
                            sda_oe  <= 1'b0;
                            sda_out <= 1'b1;
                            st      <= ST_SKIP;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R11: a stop always frees the data line
    assert_stop_frees_line_R11: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !sda_oe);
    // R5: a byte is only taken while the target owns the line
    assert_take_while_driving_R5: assert property (@(posedge clk) disable iff (rst)
        rd_take |-> sda_oe);
    // R1: a low drive only exists in acknowledge or read phases
    assert_low_only_ack_or_read_R1: assert property (@(posedge clk) disable iff (rst)
        (sda_oe && !sda_out) |-> (st == ST_ACK || st == ST_RD));
    // R6: write, parity and command strobes never coincide
    assert_strobes_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_valid, parity_err, ccc_valid}));
    // R4: after a parity failure no write byte follows in the next cycle
    assert_no_write_after_perr_R4: assert property (@(posedge clk) disable iff (rst)
        parity_err |=> !wr_valid);
endmodule

// File: rtl/sdrt_target.sv
module sdrt_target
    import sdrt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              sda_out,
    input  logic              addr_set,
    input  logic [ADDR_W-1:0] addr_new,
    output logic              wr_valid,
    output logic              wr_first,
    output logic [BYTE_W-1:0] wr_data,
    output logic              parity_err,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic              rd_more,
    output logic              rd_take,
    output logic              ccc_valid,
    output logic              ccc_direct,
    output logic [BYTE_W-1:0] ccc_code
);
    line_ev_t          ev;
    logic              da_valid, addr_clear;
    logic [ADDR_W-1:0] da_value;

    sdrt_line_events u_events (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    sdrt_addr_slot #(.AW(ADDR_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .set_en    (addr_set),
        .set_value (addr_new),
        .clear     (addr_clear),
        .valid     (da_valid),
        .value     (da_value)
    );

    sdrt_frame_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .sda_i      (sda_i),
        .ev         (ev),
        .da_valid   (da_valid),
        .da_value   (da_value),
        .addr_clear (addr_clear),
        .sda_oe     (sda_oe),
        .sda_out    (sda_out),
        .wr_valid   (wr_valid),
        .wr_first   (wr_first),
        .wr_data    (wr_data),
        .parity_err (parity_err),
        .rd_data    (rd_data),
        .rd_more    (rd_more),
        .rd_take    (rd_take),
        .ccc_valid  (ccc_valid),
        .ccc_direct (ccc_direct),
        .ccc_code   (ccc_code)
    );
endmodule

// File: tb/test_sdrt_target.sv
module test_sdrt_target;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       sda_bus;
    logic       sda_oe, sda_out;
    logic       addr_set = 1'b0;
    logic [6:0] addr_new = '0;
    logic       wr_valid, wr_first, parity_err, rd_take;
    logic [7:0] wr_data, ccc_code;
    logic       ccc_valid, ccc_direct;
    logic [7:0] rd_data_r = 8'hFF;
    logic       rd_more_r = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_perr = 0;
    logic [8:0] exp_wr[$];
    logic [8:0] exp_ccc[$];
    logic [7:0] rd_q[$];
    logic [8:0] e_item;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_bus = sda_oe ? sda_out : sda_m;

    sdrt_target i_sdrt_target (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe(sda_oe), .sda_out(sda_out),
        .addr_set(addr_set), .addr_new(addr_new),
        .wr_valid(wr_valid), .wr_first(wr_first), .wr_data(wr_data),
        .parity_err(parity_err),
        .rd_data(rd_data_r), .rd_more(rd_more_r), .rd_take(rd_take),
        .ccc_valid(ccc_valid), .ccc_direct(ccc_direct), .ccc_code(ccc_code)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
        end
    endtask

    function automatic void rd_update();
        rd_data_r = (rd_q.size() > 0) ? rd_q[0] : 8'hFF;
        rd_more_r = (rd_q.size() > 1);
    endfunction

    // reference model: strobes compared against expected events on every clock
    always @(negedge clk) begin
        if (!rst) begin
            if (wr_valid) begin
                if (exp_wr.size() == 0) chk(0, "R4 unexpected write", {wr_first, wr_data}, 0);
                else begin
                    e_item = exp_wr.pop_front();
                    chk({wr_first, wr_data} == e_item, "R3 write byte", {wr_first, wr_data}, e_item);
                end
            end
            if (ccc_valid) begin
                if (exp_ccc.size() == 0) chk(0, "R6 unexpected command", {ccc_direct, ccc_code}, 0);
                else begin
                    e_item = exp_ccc.pop_front();
                    chk({ccc_direct, ccc_code} == e_item, "R7 command event", {ccc_direct, ccc_code}, e_item);
                end
            end
            if (parity_err) begin
                chk(exp_perr > 0, "R4 parity error strobe", 1, exp_perr);
                if (exp_perr > 0) exp_perr--;
            end
            if (rd_take) begin
                chk(rd_q.size() > 0, "R5 take with nothing offered", rd_q.size(), 1);
                if (rd_q.size() > 0) void'(rd_q.pop_front());
                rd_update();
            end
        end
    end

    task automatic half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic bit_out(input logic b, output logic s);
        sda_m = b;
        half();
        scl_m = 1'b1;
        half();
        s = sda_bus;
        scl_m = 1'b0;
    endtask

    task automatic start_cond();
        sda_m = 1'b1; half();
        scl_m = 1'b1; half();
        sda_m = 1'b0; half();
        scl_m = 1'b0; half();
    endtask

    task automatic stop_cond();
        sda_m = 1'b0; half();
        scl_m = 1'b1; half();
        sda_m = 1'b1; half();
    endtask

    task automatic hdr(input logic [6:0] a, input logic rw, output logic ack);
        logic [7:0] v;
        logic s;
        v = {a, rw};
        for (int i = 7; i >= 0; i--) bit_out(v[i], s);
        bit_out(1'b1, s);
        ack = ~s;
    endtask

    task automatic wr_byte(input logic [7:0] b, input bit good);
        logic s;
        for (int i = 7; i >= 0; i--) bit_out(b[i], s);
        bit_out(good ? ~^b : ^b, s);
    endtask

    task automatic rd_byte(output logic [7:0] d, output logic t);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_out(1'b1, s);
            d[i] = s;
        end
        bit_out(1'b1, t);
    endtask

    task automatic set_addr(input logic [6:0] a);
        @(negedge clk);
        addr_set = 1'b1; addr_new = a;
        @(negedge clk);
        addr_set = 1'b0;
    endtask

    task automatic wr_byte_collide(input logic [7:0] b, input logic [6:0] na);
        logic s;
        for (int i = 7; i >= 0; i--) bit_out(b[i], s);
        sda_m = ~^b;
        half();
        scl_m = 1'b1;
        @(negedge clk);
        addr_set = 1'b1; addr_new = na;
        @(negedge clk);
        addr_set = 1'b0;
        repeat (HALF - 2) @(negedge clk);
        scl_m = 1'b0;
    endtask

    task automatic drained(input string tag);
        chk(exp_wr.size() == 0, tag, exp_wr.size(), 0);
        chk(exp_ccc.size() == 0, tag, exp_ccc.size(), 0);
        chk(exp_perr == 0, tag, exp_perr, 0);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic ack;
        logic t;
        logic [7:0] d;

        repeat (5) @(negedge clk);
        chk(sda_oe == 1'b0, "R11 reset sda_oe", sda_oe, 0);
        chk({wr_valid, parity_err, rd_take, ccc_valid} == 4'b0, "R11 reset strobes",
            {wr_valid, parity_err, rd_take, ccc_valid}, 0);
        rst = 1'b0;
        rd_update();
        repeat (3) @(negedge clk);

        // no address yet
        start_cond();
        hdr(7'h7E, 1'b0, ack);
        chk(ack == 1'b1, "R1 broadcast header ack without address", ack, 1);
        start_cond();
        hdr(7'h15, 1'b0, ack);
        chk(ack == 1'b0, "R9 no match without address", ack, 0);
        stop_cond();
        @(negedge clk);
        chk(sda_oe == 1'b0, "R11 released after stop", sda_oe, 0);

        set_addr(7'h15);

        // private write
        exp_wr.push_back({1'b1, 8'h10});
        exp_wr.push_back({1'b0, 8'hA5});
        exp_wr.push_back({1'b0, 8'h00});
        start_cond();
        hdr(7'h7E, 1'b0, ack);
        chk(ack == 1'b1, "R1 broadcast header ack", ack, 1);
        start_cond();
        hdr(7'h15, 1'b0, ack);
        chk(ack == 1'b1, "R2 own write header ack", ack, 1);
        wr_byte(8'h10, 1'b1);
        wr_byte(8'hA5, 1'b1);
        wr_byte(8'h00, 1'b1);
        stop_cond();
        repeat (3) @(negedge clk);
        drained("R3 write stream drained");

        // mismatching header: ignored, line never driven
        start_cond();
        hdr(7'h7E, 1'b0, ack);
        start_cond();
        hdr(7'h22, 1'b0, ack);
        chk(ack == 1'b0, "R2 foreign write header not acked", ack, 0);
        wr_byte(8'h3C, 1'b1);
        start_cond();
        hdr(7'h22, 1'b1, ack);
        chk(ack == 1'b0, "R2 foreign read header not acked", ack, 0);
        rd_byte(d, t);
        chk({d, t} == 9'h1FF, "R2 line idle after foreign read header", {d, t}, 9'h1FF);
        stop_cond();
        repeat (3) @(negedge clk);
        drained("R2 nothing delivered for foreign target");

        // parity failure
        exp_wr.push_back({1'b1, 8'h33});
        exp_perr = 1;
        start_cond();
        hdr(7'h7E, 1'b0, ack);
        start_cond();
        hdr(7'h15, 1'b0, ack);
        wr_byte(8'h33, 1'b1);
        wr_byte(8'h44, 1'b0);
        wr_byte(8'h55, 1'b1);
        stop_cond();
        repeat (3) @(negedge clk);
        drained("R4 bytes after parity failure ignored");

        // read of three bytes
        rd_q = '{8'h9C, 8'h01, 8'hE7};
        rd_update();
        start_cond();
        hdr(7'h7E, 1'b0, ack);
        start_cond();
        hdr(7'h15, 1'b1, ack);
        chk(ack == 1'b1, "R2 own read header ack", ack, 1);
        rd_byte(d, t);
        chk({d, t} == {8'h9C, 1'b1}, "R5 read byte 0 with continuation", {d, t}, {8'h9C, 1'b1});
        rd_byte(d, t);
        chk({d, t} == {8'h01, 1'b1}, "R5 read byte 1 with continuation", {d, t}, {8'h01, 1'b1});
        rd_byte(d, t);
        chk({d, t} == {8'hE7, 1'b0}, "R5 read last byte ends", {d, t}, {8'hE7, 1'b0});
        rd_byte(d, t);
        chk({d, t} == 9'h1FF, "R5 line released after last byte", {d, t}, 9'h1FF);
        stop_cond();
        chk(rd_q.size() == 0, "R5 every offered byte taken", rd_q.size(), 0);

        // write index then read
        exp_wr.push_back({1'b1, 8'h20});
        rd_q = '{8'h5A};
        rd_update();
        start_cond();
        hdr(7'h7E, 1'b0, ack);
        start_cond();
        hdr(7'h15, 1'b0, ack);
        wr_byte(8'h20, 1'b1);
        start_cond();
        hdr(7'h15, 1'b1, ack);
        chk(ack == 1'b1, "R2 read after repeated start acked", ack, 1);
        rd_byte(d, t);
        chk({d, t} == {8'h5A, 1'b0}, "R5 single read byte", {d, t}, {8'h5A, 1'b0});
        stop_cond();
        repeat (3) @(negedge clk);
        drained("R3 index write then read");

        // broadcast command with trailing data byte
        exp_ccc.push_back({1'b0, 8'h01});
        start_cond();
        hdr(7'h7E, 1'b0, ack);
        wr_byte(8'h01, 1'b1);
        wr_byte(8'h0F, 1'b1);
        stop_cond();
        repeat (3) @(negedge clk);
        drained("R6 broadcast command, data not forwarded");

        // directed command naming another target then this one
        exp_ccc.push_back({1'b1, 8'h9A});
        start_cond();
        hdr(7'h7E, 1'b0, ack);
        wr_byte(8'h9A, 1'b1);
        start_cond();
        hdr(7'h22, 1'b0, ack);
        chk(ack == 1'b0, "R7 other target not acked", ack, 0);
        start_cond();
        hdr(7'h15, 1'b0, ack);
        chk(ack == 1'b1, "R7 directed header acked", ack, 1);
        stop_cond();
        repeat (3) @(negedge clk);
        drained("R7 directed command reported");

        // stop drops a held directed command
        exp_wr.push_back({1'b1, 8'h12});
        start_cond();
        hdr(7'h7E, 1'b0, ack);
        wr_byte(8'h91, 1'b1);
        stop_cond();
        start_cond();
        hdr(7'h15, 1'b0, ack);
        wr_byte(8'h12, 1'b1);
        stop_cond();
        repeat (3) @(negedge clk);
        drained("R7 held command dropped by stop");

        // broadcast address discard
        exp_ccc.push_back({1'b0, 8'h06});
        start_cond();
        hdr(7'h7E, 1'b0, ack);
        wr_byte(8'h06, 1'b1);
        stop_cond();
        start_cond();
        hdr(7'h7E, 1'b0, ack);
        chk(ack == 1'b1, "R8 broadcast still acked", ack, 1);
        start_cond();
        hdr(7'h15, 1'b0, ack);
        chk(ack == 1'b0, "R8 address gone after broadcast discard", ack, 0);
        stop_cond();

        // directed address discard
        set_addr(7'h33);
        exp_ccc.push_back({1'b1, 8'h86});
        start_cond();
        hdr(7'h7E, 1'b0, ack);
        wr_byte(8'h86, 1'b1);
        start_cond();
        hdr(7'h33, 1'b0, ack);
        chk(ack == 1'b1, "R8 directed discard acked", ack, 1);
        stop_cond();
        start_cond();
        hdr(7'h33, 1'b0, ack);
        chk(ack == 1'b0, "R8 address gone after directed discard", ack, 0);
        stop_cond();
        repeat (3) @(negedge clk);
        drained("R8 discard commands reported");

        // load and discard in the same cycle
        set_addr(7'h40);
        exp_ccc.push_back({1'b0, 8'h06});
        start_cond();
        hdr(7'h7E, 1'b0, ack);
        wr_byte_collide(8'h06, 7'h41);
        stop_cond();
        start_cond();
        hdr(7'h41, 1'b0, ack);
        chk(ack == 1'b1, "R10 new address survives discard", ack, 1);
        start_cond();
        hdr(7'h40, 1'b0, ack);
        chk(ack == 1'b0, "R10 old address not matched", ack, 0);
        stop_cond();
        repeat (3) @(negedge clk);
        drained("R10 collision command reported");

        finish_run();
    end
endmodule